// File: doc/BRIEF.md
# Multiplexer Logic Cell with Configurable Storage

This block models one logic cell of a multiplexer-based programmable array. A four-way data selector forms the combinational output. The selector's two control bits come from small gates on pairs of control inputs. The selected value also feeds a storage element. That storage element is built from two latches in series. The configuration input chooses between two behaviours. In one, the element is a rising-edge flip-flop. In the other, it is a level-sensitive latch that is transparent while the clock is high.

A parameter picks the combinational core. The default core drives the high selector bit from an AND of two inputs and the low bit from an OR of two inputs. The alternative core uses two 2:1 selectors. A third selector chooses between them, controlled by the OR of two more inputs. With suitable input wiring, the default core can realise functions such as (A·B)+(B'·C)+D. An active-high clear empties the storage at once, in both modes. An active-low reset loads zero through the normal capture path.

Top module: `mux_logic_cell`

## Requirements
- R1: With the default core, the high select bit is sel_in[3] AND sel_in[2], the low select bit is sel_in[1] OR sel_in[0], and y equals dat[{high,low}] for all 256 input combinations.
- R2: With the alternative core, y is dat[1:0] chosen by sel_in[0] (dat[0] when 0) when sel_in[2] OR sel_in[3] is 0; otherwise y is dat[3:2] chosen by sel_in[1] (dat[2] when 0).
- R3: The default core wired as sel_in={B,B,D,D} and dat={1,A,1,C} produces F=(A·B)+(B'·C)+D for all 16 values of A,B,C,D.
- R4: With cfg_edge=1, q takes the stored value only at a rising clk edge and holds it through any input change between edges.
- R5: With cfg_edge=0, q follows the stored value while clk is high and holds it while clk is low.
- R6: clr=1 forces q to 0 at once, without a clock edge, in both modes, and holds it there while asserted.
- R7: With rst_n=0, the value stored (at the capture edge or during the transparent phase) is 0, while y is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock; edge in flip-flop mode, level in latch mode |
| rst_n | input | 1 | Active-low reset, applied through the capture path |
| clr | input | 1 | Active-high asynchronous clear of the storage |
| cfg_edge | input | 1 | 1 = rising-edge flip-flop, 0 = high-transparent latch |
| dat | input | 4 | Selector data inputs, index = {high select, low select} |
| sel_in | input | 4 | Gate inputs that form the select bits |
| y | output | 1 | Combinational selector output |
| q | output | 1 | Stored output |

## Verification
The output y changes in the same time step as dat or sel_in, so combinational checks settle 1 ns after each input change. In flip-flop mode, q changes only at the rising edge of clk. In latch mode, q changes whenever the stored value moves while clk is high. A clear affects q immediately. Inputs change 1 ns after a falling edge or 2 ns after a rising edge. The reference model is compared 4 ns after every edge, which is after each due change and before the next input change. Directed checks sample 1 ns after a clear is raised.

// File: rtl/mux_cell_pkg.sv
// Shared constants and the core-variant type for the multiplexer cell.
package mux_cell_pkg;
    parameter int MC_DATA_N = 4;  // data inputs of the selector
    parameter int MC_SEL_N  = 4;  // gate inputs that form the selects

    typedef enum logic {
        CORE_QUAD = 1'b0,  // 4:1 selector, AND/OR select gates
        CORE_PAIR = 1'b1   // two 2:1 selectors plus an OR-controlled third
    } core_kind_e;
endpackage

// File: rtl/mux_cell_comb.sv
// Combinational core of the cell. The CORE parameter picks the variant.
// Assumes: pure logic, no state; sel_in bit roles depend on the variant.
module mux_cell_comb
    import mux_cell_pkg::*;
#(
    parameter core_kind_e CORE = CORE_QUAD
) (
    input  logic [MC_DATA_N-1:0] dat,
    input  logic [MC_SEL_N-1:0]  sel_in,
    output logic                 y
);
    localparam int IDX_W = $clog2(MC_DATA_N);

    generate
        if (CORE == CORE_QUAD) begin : g_quad
            logic [IDX_W-1:0] pick;
            // Form the select index from an AND pair and an OR pair.
            always_comb begin
                pick[1] = sel_in[3] & sel_in[2];
                pick[0] = sel_in[1] | sel_in[0];
            end
            // Four-way data selection.
            always_comb y = dat[pick];
        end else begin : g_pair
            logic lo_pick, hi_pick, grp;
            // Two first-level 2:1 selectors.
            always_comb begin
                lo_pick = sel_in[0] ? dat[1] : dat[0];
                hi_pick = sel_in[1] ? dat[3] : dat[2];
                grp     = sel_in[2] | sel_in[3];
            end
            // Final selector under the OR of the group selects.
            always_comb y = grp ? hi_pick : lo_pick;
        end
    endgenerate
endmodule

// File: rtl/mux_cell_latch.sv
// One level-sensitive latch with asynchronous active-high clear.
// Assumes: en is a level; clear dominates.
module mux_cell_latch (
    input  logic en,
    input  logic clr,
    input  logic d,
    output logic q
);
    // Clear first, otherwise pass d while enabled.
    always_latch begin
        if (clr)
            q = 1'b0;
        else if (en)
            q = d;
    end
endmodule

// File: rtl/mux_cell_seq.sv
// Storage element: a master latch feeding a slave latch, with a shared clear.
// In edge mode the master is open while clk is low, so the pair acts as a
// rising-edge flip-flop. In latch mode the master is held open, so the
// slave alone gives a latch that is transparent while clk is high.
module mux_cell_seq (
    input  logic clk,
    input  logic clr,
    input  logic edge_mode,
    input  logic d,
    output logic q
);
    logic en_master, mid;

    // Master enable depends on the configured mode.
    always_comb en_master = edge_mode ? ~clk : 1'b1;

    mux_cell_latch u_master (.en(en_master), .clr(clr), .d(d),   .q(mid));
    mux_cell_latch u_slave  (.en(clk),       .clr(clr), .d(mid), .q(q));

    // R6: clear holds the output at zero.
    p_clr_zero_r6: assert property (@(posedge clk) clr |-> (q == 1'b0))
        else $error("clear did not force q low");

    // R4: edge mode delivers the value present at the previous rising edge.
    p_ff_capture_r4: assert property (@(posedge clk) disable iff (clr)
        edge_mode |=> (!edge_mode || q == $past(d)))
        else $error("edge capture mismatch");

    // R5: latch mode is transparent through the high phase.
    p_latch_follow_r5: assert property (@(negedge clk) disable iff (clr)
        !edge_mode |-> (q == d))
        else $error("latch not transparent while clk high");
endmodule

// File: rtl/mux_logic_cell.sv
// Top of the multiplexer logic cell: combinational core plus storage.
// Assumes: rst_n is sampled through the capture path (synchronous), and
// clr is asynchronous and dominant.
module mux_logic_cell
    import mux_cell_pkg::*;
#(
    parameter core_kind_e CORE = CORE_QUAD
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 cfg_edge,
    input  logic [MC_DATA_N-1:0] dat,
    input  logic [MC_SEL_N-1:0]  sel_in,
    output logic                 y,
    output logic                 q
);
    logic d_store;

    mux_cell_comb #(.CORE(CORE)) u_comb (.dat(dat), .sel_in(sel_in), .y(y));

    // Reset gates the value offered to the storage element.
    always_comb d_store = rst_n ? y : 1'b0;

    mux_cell_seq u_seq (
        .clk(clk), .clr(clr), .edge_mode(cfg_edge), .d(d_store), .q(q)
    );

    // R7: reset in edge mode loads zero at the edge.
    p_rst_load_r7: assert property (@(posedge clk) disable iff (clr)
        (!rst_n && cfg_edge) |=> (!cfg_edge || q == 1'b0))
        else $error("reset did not load zero");

    generate
        if (CORE == CORE_QUAD) begin : g_chk_quad
            // R1: both AND inputs high and both OR inputs low selects dat[2].
            p_comb_pick_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_in == 4'b1100) |-> (y == dat[2]))
                else $error("selector picked wrong input");
        end
    endgenerate
endmodule

// File: tb/sim_mux_logic_cell.sv
module sim_mux_logic_cell;
    import mux_cell_pkg::*;

    logic clk = 1'b0;
    logic rst_n, clr, cfg_edge;
    logic [3:0] dat, sel_in;
    logic y0, q0, y1, q1;
    int n_chk = 0, n_fail = 0;
    logic qm0, qm1, clk_d;
    int unsigned seed = 32'h1234_5678;

    always #5 clk = ~clk;  // 100 MHz

    mux_logic_cell #(.CORE(CORE_QUAD)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_edge(cfg_edge),
        .dat(dat), .sel_in(sel_in), .y(y0), .q(q0));
    mux_logic_cell #(.CORE(CORE_PAIR)) u1 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_edge(cfg_edge),
        .dat(dat), .sel_in(sel_in), .y(y1), .q(q1));

    // Behavioural expectation of y from the requirement text.
    function automatic logic ref_y(input logic pair, input logic [3:0] d,
                                   input logic [3:0] s);
        int idx;
        if (!pair) begin
            idx = 0;
            if (s[3] == 1'b1 && s[2] == 1'b1) idx = idx + 2;
            if (s[1] == 1'b1 || s[0] == 1'b1) idx = idx + 1;
            return d[idx];
        end
        if (s[2] == 1'b1 || s[3] == 1'b1) return s[1] ? d[3] : d[2];
        return s[0] ? d[1] : d[0];
    endfunction

    // Event-driven model of the stored outputs.
    initial clk_d = 1'b0;
    always @(clk or clr or cfg_edge or rst_n or dat or sel_in) begin
        logic e0, e1;
        e0 = rst_n ? ref_y(1'b0, dat, sel_in) : 1'b0;
        e1 = rst_n ? ref_y(1'b1, dat, sel_in) : 1'b0;
        if (clr) begin
            qm0 = 1'b0; qm1 = 1'b0;
        end else if (cfg_edge) begin
            if (clk && !clk_d) begin qm0 = e0; qm1 = e1; end
        end else if (clk) begin
            qm0 = e0; qm1 = e1;
        end
        clk_d = clk;
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cmp_all();
        chk("R1 y quad", y0, ref_y(1'b0, dat, sel_in));
        chk("R2 y pair", y1, ref_y(1'b1, dat, sel_in));
        chk("R4/R5/R6/R7 q quad", q0, qm0);
        chk("R4/R5/R6/R7 q pair", q1, qm1);
    endtask

    // Compare against the model after every clock edge.
    always @(posedge clk) begin #4; cmp_all(); end
    always @(negedge clk) begin #4; cmp_all(); end

    function automatic logic [7:0] next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[23:16];
    endfunction

    // Random cycles: change at falling edge, sometimes again in the high phase.
    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] r;
            @(negedge clk); #1;
            r = next_rand();
            {sel_in, dat} = r;
            @(posedge clk); #2;
            if (i % 2 == 1) begin
                r = next_rand();
                {sel_in, dat} = r;
            end
        end
    endtask

    initial begin
        clr = 1'b1; rst_n = 1'b1; cfg_edge = 1'b1; dat = '0; sel_in = '0;
        #2;
        chk("R6 reset state quad", q0, 1'b0);
        chk("R6 reset state pair", q1, 1'b0);

        // R1 / R2: exhaustive combinational sweep.
        for (int i = 0; i < 256; i++) begin
            logic [7:0] v;
            v = i[7:0];
            {sel_in, dat} = v;
            #1;
            chk("R1 sweep", y0, ref_y(1'b0, dat, sel_in));
            chk("R2 sweep", y1, ref_y(1'b1, dat, sel_in));
        end

        // R3: F = A.B + B'.C + D through input wiring.
        for (int i = 0; i < 16; i++) begin
            logic a, b, c, dd;
            {a, b, c, dd} = i[3:0];
            sel_in = {b, b, dd, dd};
            dat    = {1'b1, a, 1'b1, c};
            #1;
            chk("R3 function", y0, (a & b) | (~b & c) | dd);
        end

        // R4: edge mode.
        @(negedge clk); #1; clr = 1'b0; cfg_edge = 1'b1;
        run_cycles(40);
        // R4: in-cycle change must not reach q.
        @(negedge clk); #1; sel_in = 4'b0000; dat = 4'b0001;
        @(posedge clk); #2; dat = 4'b0000;
        #1; chk("R4 hold between edges", q0, 1'b1);

        // R7: reset in edge mode, y stays 1.
        @(negedge clk); #1; rst_n = 1'b0; dat = 4'hF;
        @(posedge clk); #1;
        chk("R7 reset load", q0, 1'b0);
        chk("R7 y unaffected", y0, 1'b1);
        @(negedge clk); #1; rst_n = 1'b1;
        @(posedge clk); #1; chk("R7 release", q0, 1'b1);

        // R6: asynchronous clear in edge mode.
        @(posedge clk); #2; clr = 1'b1;
        #1; chk("R6 async clear edge mode", q0, 1'b0);
        @(negedge clk); #1; cfg_edge = 1'b0;
        @(negedge clk); #1; clr = 1'b0;

        // R5: latch mode.
        run_cycles(40);
        @(posedge clk); #2; dat = 4'h0;
        #1; chk("R5 transparent high", q0, 1'b0);
        @(negedge clk); #1; dat = 4'hF;
        #2; chk("R5 hold low", q0, 1'b0);

        // R7: reset during transparent phase.
        @(posedge clk); #1; chk("R5 follow", q0, 1'b1);
        #1; rst_n = 1'b0;
        #1; chk("R7 reset latch mode", q0, 1'b0);
        @(negedge clk); #1; rst_n = 1'b1;

        // R6: asynchronous clear in latch mode while clk high.
        @(posedge clk); #1; chk("R5 follow again", q0, 1'b1);
        #1; clr = 1'b1;
        #1; chk("R6 async clear latch mode", q0, 1'b0);
        @(negedge clk); #1; clr = 1'b0;
        run_cycles(10);

        @(negedge clk); #6;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        #1500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule